// File: doc/BRIEF.md
# Reset Cause and Control Register

This block is a single 32-bit status-and-control word that tells software why the system last came out of reset and lets software ask for a new system reset. It sits on a simple synchronous register port. Only the upper 32-bit word of one 64-bit-strided location decodes: any byte offset from 0xF020 to 0xF027 hits the location, and address bit 2 selects the live upper word. The lower word and every other address read as zero and ignore writes.

Five bits at the top of the word carry meaning. Bit 31 (power-up cause), bit 28 (power-button cause) and bit 27 (external-reset-button cause) are cause flags. Writing a one clears them, and the two button inputs set bits 28 and 27 directly. Bit 30 (software power-up request) and bit 29 (software external-reset request) are set by writing a one and are never cleared by writing zero. Writing either of them issues a one-cycle reset request, with a flag that says whether a power-up style reset was asked for.

A software power-up request also arms first-reset tracking. The next reset-complete event then reloads the word with only bit 31 set and disarms tracking. Any later reset-complete event leaves the word as it is.

Top module: `reset_cause_reg`

## Requirements
- R1: After the synchronous reset input, the word reads 0x80000000, no request pulse is active and first-reset tracking is disarmed.
- R2: Only addresses whose bits [15:3] equal 0xF020>>3 and whose bit 2 is one reach the word. Reads return it one cycle later. Reads elsewhere, including offset 0xF020, return 0. Writes elsewhere change nothing.
- R3: Bits 26 down to 0 always read zero, whatever data is written.
- R4: Writing a one to bit 31, 28 or 27 clears that bit. Writing zero there leaves it unchanged.
- R5: Writing a one to bit 30 or 29 sets it. Writing zero leaves it unchanged.
- R6: A write with bit 30 set gives `reset_req` high for exactly the cycle after the write, with `reset_req_power_on` high. The write also arms first-reset tracking.
- R7: A write with bit 29 set and bit 30 clear gives the same one-cycle `reset_req` with `reset_req_power_on` low. It does not arm tracking.
- R8: A `sys_reset_done` pulse while tracking is armed loads the word with exactly 0x80000000 and disarms tracking. While tracking is disarmed, the pulse leaves the word unchanged.
- R9: `btn_power` sets bit 28 and `btn_extrst` sets bit 27 at the clock edge on which they are sampled high.
- R10: When a write clears bit 28 or 27 in the same cycle as the matching button input is high, the bit ends up set.
- R11: A write in the same cycle as `sys_reset_done` is dropped. It changes no bit and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, zero when not reading |
| sys_reset_done | input | 1 | One-cycle reset-complete event |
| btn_power | input | 1 | Power-button event |
| btn_extrst | input | 1 | External-reset-button event |
| reset_req | output | 1 | One-cycle system reset request |
| reset_req_power_on | output | 1 | Request kind: 1 power-up, 0 external |

## Verification
The hardest state to reach from the ports is a reset-complete event landing while tracking is armed. A collision between a write and a button, or between a write and a reset-complete event, is nearly as hard. Directed steps first arm tracking with a bit-30 write. They then fire the event once while armed and once while disarmed, and they stage a clear-versus-button collision and a write-versus-event collision on purpose. A seeded random phase follows. It weights writes toward the live word and draws events and button pulses often enough that those collisions keep recurring. A bench model of the word and the armed flag predicts every read and every request.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  // positions inside the five-bit cause field (field bit 4 = word bit 31)
  localparam int FIELD_W  = 5;
  localparam int F_PWRUP  = 4;
  localparam int F_SWPWR  = 3;
  localparam int F_SWEXT  = 2;
  localparam int F_BTNPWR = 1;
  localparam int F_BTNEXT = 0;

  localparam logic [FIELD_W-1:0] W1C_FIELD   = 5'b10011;
  localparam logic [FIELD_W-1:0] SET_FIELD   = 5'b01100;
  localparam logic [FIELD_W-1:0] PWRUP_FIELD = 5'b10000;

  typedef struct packed {
    logic valid;
    logic power_on;
  } rst_req_t;
endpackage

// File: rtl/rstc_decode.sv
module rstc_decode #(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  logic slot_match;
  logic upper_word;

  assign slot_match = (addr_i[ADDR_W-1:3] == REG_OFFSET[ADDR_W-1:3]);
  assign upper_word = addr_i[2];
  assign wr_hit_o   = wr_i && slot_match && upper_word;
  assign rd_hit_o   = rd_i && slot_match && upper_word;
endmodule

// File: rtl/rstc_core.sv
module rstc_core
  import rstc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_hit_i,
  input  logic [FIELD_W-1:0] wfield_i,
  input  logic               evt_i,
  input  logic               btn_pwr_i,
  input  logic               btn_ext_i,
  output logic [FIELD_W-1:0] cause_o,
  output logic               armed_o,
  output rst_req_t           req_o
);
  logic [FIELD_W-1:0] cause_q, cause_n;
  logic               armed_q, armed_n;
  logic               wr_eff;

  assign wr_eff = wr_hit_i && !evt_i;

  always_comb begin
    cause_n = cause_q;
    armed_n = armed_q;
    if (evt_i) begin
      if (armed_q) begin
        cause_n = PWRUP_FIELD;
        armed_n = 1'b0;
      end
    end else if (wr_hit_i) begin
      cause_n = (cause_q & ~(wfield_i & W1C_FIELD)) | (wfield_i & SET_FIELD);
      if (wfield_i[F_SWPWR]) armed_n = 1'b1;
    end
    if (btn_pwr_i) cause_n[F_BTNPWR] = 1'b1;
    if (btn_ext_i) cause_n[F_BTNEXT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= PWRUP_FIELD;
      armed_q <= 1'b0;
    end else begin
      cause_q <= cause_n;
      armed_q <= armed_n;
    end
  end

  assign req_o.valid    = wr_eff && (wfield_i[F_SWPWR] || wfield_i[F_SWEXT]);
  assign req_o.power_on = wr_eff && wfield_i[F_SWPWR];
  assign cause_o        = cause_q;
  assign armed_o        = armed_q;

  // R8
  armed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i && armed_q && !btn_pwr_i && !btn_ext_i) |=> (cause_q == PWRUP_FIELD && !armed_q));
  // R10
  btn_wins_chk: assert property (@(posedge clk) disable iff (rst)
    btn_pwr_i |=> cause_q[F_BTNPWR]);
  // R5
  req_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit_i && !evt_i) |=> $stable(cause_q[F_SWPWR:F_SWEXT]));
  // R11
  evt_drops_write_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i && !armed_q && !btn_pwr_i && !btn_ext_i) |=> $stable(cause_q));
endmodule

// File: rtl/rstc_pulse.sv
module rstc_pulse
  import rstc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rst_req_t req_i,
  output logic     req_o,
  output logic     power_on_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o      <= 1'b0;
      power_on_o <= 1'b0;
    end else begin
      req_o      <= req_i.valid;
      power_on_o <= req_i.valid && req_i.power_on;
    end
  end

  // R6
  kind_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    power_on_o |-> req_o);
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rstc_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 16'hF020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sys_reset_done,
  input  logic              btn_power,
  input  logic              btn_extrst,
  output logic              reset_req,
  output logic              reset_req_power_on
);
  localparam int LOW_W = DATA_W - FIELD_W;

  logic               wr_hit, rd_hit;
  logic [FIELD_W-1:0] cause;
  logic               armed;
  rst_req_t           req_next;

  rstc_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) i_decode (
    .addr_i   (bus_addr),
    .wr_i     (bus_wr),
    .rd_i     (bus_rd),
    .wr_hit_o (wr_hit),
    .rd_hit_o (rd_hit)
  );

  rstc_core i_core (
    .clk       (clk),
    .rst       (rst),
    .wr_hit_i  (wr_hit),
    .wfield_i  (bus_wdata[DATA_W-1 -: FIELD_W]),
    .evt_i     (sys_reset_done),
    .btn_pwr_i (btn_power),
    .btn_ext_i (btn_extrst),
    .cause_o   (cause),
    .armed_o   (armed),
    .req_o     (req_next)
  );

  rstc_pulse i_pulse (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_next),
    .req_o      (reset_req),
    .power_on_o (reset_req_power_on)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_hit ? {cause, {LOW_W{1'b0}}} : '0;
  end

  // R3
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[LOW_W-1:0] == '0);
  // R7
  req_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(bus_wr && bus_addr[2] && !sys_reset_done
                        && (bus_wdata[DATA_W-2] || bus_wdata[DATA_W-3])));
  // R6
  arm_on_swpwr_chk: assert property (@(posedge clk) disable iff (rst)
    (reset_req && reset_req_power_on) |-> armed);
endmodule

// File: tb/test_reset_cause_reg.sv
module test_reset_cause_reg;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        sys_reset_done, btn_power, btn_extrst;
  logic        reset_req, reset_req_power_on;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  logic [31:0] m_word;
  logic        m_armed;

  always #10 clk = ~clk;  // 50 MHz

  reset_cause_reg i_reset_cause_reg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_reset_done(sys_reset_done),
    .btn_power(btn_power), .btn_extrst(btn_extrst), .reset_req(reset_req),
    .reset_req_power_on(reset_req_power_on)
  );

  function automatic logic is_live(input logic [15:0] a);
    return (a[15:3] == 13'h1E04) && a[2];
  endfunction

  // one step: drive at a falling edge, predict, let one rising edge pass, compare
  task automatic step(input logic wr, input logic rd, input logic [15:0] a,
                      input logic [31:0] d, input logic evt, input logic bp,
                      input logic bx, input string tag);
    logic [31:0] exp_rd;
    logic        exp_req, exp_pwr;
    logic [31:0] dm;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    sys_reset_done = evt; btn_power = bp; btn_extrst = bx;
    exp_rd  = (rd && is_live(a)) ? m_word : 32'h0;
    dm      = d & 32'hF800_0000;
    exp_req = wr && is_live(a) && !evt && (dm[30] || dm[29]);
    exp_pwr = exp_req && dm[30];
    if (evt) begin
      if (m_armed) begin m_word = 32'h8000_0000; m_armed = 1'b0; end
    end else if (wr && is_live(a)) begin
      m_word = (m_word & ~(dm & 32'h9800_0000)) | (dm & 32'h6000_0000);
      if (dm[30]) m_armed = 1'b1;
    end
    if (bp) m_word[28] = 1'b1;
    if (bx) m_word[27] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (bus_rdata !== exp_rd || reset_req !== exp_req || reset_req_power_on !== exp_pwr) begin
      n_bad++;
      $display("FAIL %s: rdata=%h req=%b pwr=%b expected rdata=%h req=%b pwr=%b",
               tag, bus_rdata, reset_req, reset_req_power_on, exp_rd, exp_req, exp_pwr);
    end
  endtask

  task automatic rd_hi(input string tag);
    step(1'b0, 1'b1, 16'hF024, 32'h0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr_hi(input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, 16'hF024, d, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    sys_reset_done = 0; btn_power = 0; btn_extrst = 0;
    m_word = 32'h8000_0000; m_armed = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    rd_hi("R1 reset value");
    step(0, 1, 16'hF020, 0, 0, 0, 0, "R2 lower word reads zero");
    step(0, 1, 16'hF02C, 0, 0, 0, 0, "R2 next slot reads zero");
    wr_hi(32'h07FF_FFFF, "R3 low bits write");
    rd_hi("R3 low bits stay zero");
    wr_hi(32'h0000_0000, "R4 zero keeps cause");
    rd_hi("R4 cause kept");
    wr_hi(32'h8000_0000, "R4 clear power-up");
    rd_hi("R4 cleared");
    step(0, 0, 16'h0, 0, 0, 1, 0, "R9 power button");
    rd_hi("R9 bit28 set");
    step(0, 0, 16'h0, 0, 0, 0, 1, "R9 ext button");
    rd_hi("R9 bit27 set");
    step(1, 0, 16'hF024, 32'h1800_0000, 0, 1, 0, "R10 clear vs button");
    rd_hi("R10 button wins bit28");
    wr_hi(32'h2000_0000, "R7 external request pulse");
    rd_hi("R7 bit29 set");
    wr_hi(32'h0000_0000, "R5 zero keeps request bits");
    rd_hi("R5 bit29 kept");
    step(0, 0, 16'h0, 0, 1, 0, 0, "R8 event while disarmed");
    rd_hi("R8 unchanged when disarmed");
    wr_hi(32'h4000_0000, "R6 power-up request pulse");
    rd_hi("R6 bit30 set");
    step(0, 0, 16'h0, 0, 1, 0, 0, "R8 event while armed");
    rd_hi("R8 loaded power-up only");
    step(0, 0, 16'h0, 0, 1, 0, 0, "R8 second event");
    rd_hi("R8 unchanged after disarm");
    step(1, 0, 16'hF020, 32'h8000_0000, 0, 0, 0, "R2 lower word write ignored");
    step(1, 0, 16'hF124, 32'h8000_0000, 0, 0, 0, "R2 other address write ignored");
    rd_hi("R2 word unchanged");
    step(1, 0, 16'hF024, 32'h4000_0000, 1, 0, 0, "R11 write with event");
    rd_hi("R11 write dropped");
    step(0, 0, 16'h0, 0, 1, 0, 0, "R11 not armed by dropped write");
    rd_hi("R11 still unchanged");

    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      int unsigned sel = $urandom_range(0, 9);
      logic [15:0] a;
      logic [31:0] d;
      case (sel % 4)
        0, 1:    a = 16'hF024;
        2:       a = 16'hF020;
        default: a = 16'($urandom);
      endcase
      d = $urandom;
      if ($urandom_range(0, 2) == 0) d[30] = 1'b0;
      step(sel < 4, (sel >= 4 && sel < 8) || sel == 9, (sel >= 4) ? 16'hF024 : a, d,
           $urandom_range(0, 7) == 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 5) == 0, "R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule